// File: doc/BRIEF.md
# Monotonic Security Level Controller

This block keeps a three-step protection level and judges, in the same cycle, whether an operation a host asks for may go ahead. Possible requests are reads and writes of program memory, block erase, blank check, fuse reads and writes, reads and writes of the two boot configuration bytes, and reads of identity data or of the level itself. A refused request comes back with one of two error classes. A refused write-type request gets a "program" refusal. A refused read-type request gets a "lock" refusal.

The level only ever moves toward stronger protection through its write port. Nothing lowers it except a full-chip erase. That erase opens the level fully and also returns the boot status byte and the boot vector byte to their factory values. The block holds the current level byte and both boot bytes and presents them as outputs. Non-volatile storage and erase timing are handled outside the block.

Top module: `prot_level_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the level byte reads FCh, the boot status byte reads FFh and the boot vector byte reads F0h.
- R2: Level bytes are FFh (open, rank 0), FEh (write-protected, rank 1) and FCh (read/write-protected, rank 2). A level write is taken on the next clock edge only if its rank is strictly above the stored rank. So FFh may go to FEh or FCh, FEh may go only to FCh, and any equal or lower write leaves the level as it was.
- R3: A level write carrying any value other than FFh, FEh or FCh is rejected and the stored level does not change.
- R4: Response codes are 2'b00 for granted, 2'b01 for a write-class refusal and 2'b10 for a read-class refusal. At level FFh every defined operation gets `grant`=1 and code 00.
- R5: At level FEh, the write-class operations are refused with code 01. These are memory write (op 1), block erase (op 2), fuse write (op 5), boot status write (op 7) and boot vector write (op 8). The read-class operations are granted: memory read (op 0), fuse read (op 4) and boot byte read (op 6).
- R6: At level FCh, write-class operations get code 01 and read-class operations get code 10.
- R7: Blank check (op 3), identity read (op 9) and level read (op 10) are granted at every level.
- R8: When `chip_erase` is pulsed, the next clock edge sets the level to FFh, the boot status byte to FFh and the boot vector byte to F0h. This takes priority over any level or boot byte write in the same cycle.
- R9: A granted boot status write (op 7) or boot vector write (op 8) loads `req_data` into that byte on the next edge. A refused one leaves the byte unchanged.
- R10: `grant` and `resp_code` follow the request in the same cycle, without a register. With `req_valid` low they read 0 and 00. Op codes 11 to 15 are refused with code 01 at every level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Operation request strobe |
| req_op | input | 4 | Operation code |
| req_data | input | 8 | Value for boot byte writes |
| grant | output | 1 | Request allowed (combinational) |
| resp_code | output | 2 | 00 granted, 01 write-class refusal, 10 read-class refusal |
| lvl_wr | input | 1 | Level write strobe |
| lvl_wdata | input | 8 | Requested level byte |
| chip_erase | input | 1 | Full-chip erase strobe |
| sec_byte | output | 8 | Current level byte |
| boot_status | output | 8 | Current boot status byte |
| boot_vector | output | 8 | Current boot vector byte |

## Verification
The grant and response code depend only on the request and the stored level, so they are due in the same cycle as the request. The bench samples them 1 ns after it drives inputs at the falling edge. Level, boot status and boot vector changes are due one rising edge later. The bench checks them at the next falling edge against a model it has already advanced. Because the reset release passes through two synchronizer flops, the bench waits several cycles after deasserting reset before it checks the reset values.

// File: rtl/seclvl_pkg.sv
package seclvl_pkg;

  localparam int DATA_W  = 8;
  localparam int OP_W    = 4;
  localparam int NUM_OPS = 1 << OP_W;

  localparam logic [DATA_W-1:0] ENC_OPEN = 8'hFF;
  localparam logic [DATA_W-1:0] ENC_WP   = 8'hFE;
  localparam logic [DATA_W-1:0] ENC_RWP  = 8'hFC;

  typedef enum logic [1:0] {
    RANK_OPEN = 2'd0,
    RANK_WP   = 2'd1,
    RANK_RWP  = 2'd2
  } rank_e;

  typedef enum logic [1:0] {
    RSP_OK    = 2'b00,
    RSP_WDENY = 2'b01,
    RSP_RDENY = 2'b10
  } rsp_e;

  typedef enum logic [1:0] {
    CLS_FREE  = 2'd0,
    CLS_READ  = 2'd1,
    CLS_WRITE = 2'd2,
    CLS_BAD   = 2'd3
  } cls_e;

  localparam logic [OP_W-1:0] OP_MEM_RD  = 4'd0;
  localparam logic [OP_W-1:0] OP_MEM_WR  = 4'd1;
  localparam logic [OP_W-1:0] OP_BLK_ERS = 4'd2;
  localparam logic [OP_W-1:0] OP_BLANK   = 4'd3;
  localparam logic [OP_W-1:0] OP_FUSE_RD = 4'd4;
  localparam logic [OP_W-1:0] OP_FUSE_WR = 4'd5;
  localparam logic [OP_W-1:0] OP_BOOT_RD = 4'd6;
  localparam logic [OP_W-1:0] OP_BSB_WR  = 4'd7;
  localparam logic [OP_W-1:0] OP_SBV_WR  = 4'd8;
  localparam logic [OP_W-1:0] OP_INFO_RD = 4'd9;
  localparam logic [OP_W-1:0] OP_LVL_RD  = 4'd10;

  typedef struct packed {
    logic  ok;
    rank_e rank;
  } dec_t;

  function automatic cls_e op_class(input logic [OP_W-1:0] op);
    case (op)
      OP_BLANK, OP_INFO_RD, OP_LVL_RD:             return CLS_FREE;
      OP_MEM_RD, OP_FUSE_RD, OP_BOOT_RD:           return CLS_READ;
      OP_MEM_WR, OP_BLK_ERS, OP_FUSE_WR,
      OP_BSB_WR, OP_SBV_WR:                        return CLS_WRITE;
      default:                                     return CLS_BAD;
    endcase
  endfunction

  function automatic dec_t enc_to_rank(input logic [DATA_W-1:0] enc);
    dec_t d;
    d.ok   = 1'b1;
    d.rank = RANK_OPEN;
    case (enc)
      ENC_OPEN: d.rank = RANK_OPEN;
      ENC_WP:   d.rank = RANK_WP;
      ENC_RWP:  d.rank = RANK_RWP;
      default:  d.ok   = 1'b0;
    endcase
    return d;
  endfunction

  function automatic logic [DATA_W-1:0] rank_to_enc(input rank_e r);
    case (r)
      RANK_OPEN: return ENC_OPEN;
      RANK_WP:   return ENC_WP;
      default:   return ENC_RWP;
    endcase
  endfunction

endpackage

// File: rtl/seclvl_rst_sync.sv
module seclvl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/seclvl_level_reg.sv
module seclvl_level_reg
  import seclvl_pkg::*;
#(
  parameter rank_e RESET_RANK = RANK_RWP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              erase_i,
  output rank_e             rank_o
);

  rank_e rank_q;
  rank_e rank_d;
  logic  rank_en;
  dec_t  wr_dec;
  logic  raise_ok;

  always_comb begin
    wr_dec   = enc_to_rank(wr_data_i);
    raise_ok = wr_en_i && wr_dec.ok && (wr_dec.rank > rank_q);
    rank_en  = erase_i || raise_ok;
    if (erase_i) begin
      rank_d = RANK_OPEN;
    end else if (raise_ok) begin
      rank_d = wr_dec.rank;
    end else begin
      rank_d = rank_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rank_q <= RESET_RANK;
    end else if (rank_en) begin
      rank_q <= rank_d;
    end
  end

  assign rank_o = rank_q;

  AST_LVL_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_i |=> (rank_q >= $past(rank_q))); // R2
  AST_LVL_BAD_ENC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !erase_i && (wr_data_i != ENC_OPEN) && (wr_data_i != ENC_WP)
     && (wr_data_i != ENC_RWP)) |=> $stable(rank_q)); // R3
  AST_LVL_ERASE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    erase_i |=> (rank_q == RANK_OPEN)); // R8
  AST_LVL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rank_q != 2'd3); // R2

endmodule

// File: rtl/seclvl_policy.sv
module seclvl_policy
  import seclvl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid_i,
  input  logic [OP_W-1:0] req_op_i,
  input  rank_e           rank_i,
  output logic            grant_o,
  output rsp_e            rsp_o
);

  cls_e cls_tab [NUM_OPS];
  cls_e cls_sel;
  rsp_e rsp_raw;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
    assign cls_tab[g] = op_class(OP_W'(g));
  end

  assign cls_sel = cls_tab[req_op_i];

  always_comb begin
    case (cls_sel)
      CLS_FREE:  rsp_raw = RSP_OK;
      CLS_READ:  rsp_raw = (rank_i == RANK_RWP) ? RSP_RDENY : RSP_OK;
      CLS_WRITE: rsp_raw = (rank_i != RANK_OPEN) ? RSP_WDENY : RSP_OK;
      default:   rsp_raw = RSP_WDENY;
    endcase
    rsp_o   = req_valid_i ? rsp_raw : RSP_OK;
    grant_o = req_valid_i && (rsp_raw == RSP_OK);
  end

  AST_FREE_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && (req_op_i == OP_BLANK || req_op_i == OP_INFO_RD
     || req_op_i == OP_LVL_RD)) |-> grant_o); // R7
  AST_RWP_NO_MEMRD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && rank_i == RANK_RWP && req_op_i == OP_MEM_RD)
    |-> (!grant_o && rsp_o == RSP_RDENY)); // R6
  AST_WP_NO_MEMWR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && rank_i == RANK_WP && req_op_i == OP_MEM_WR)
    |-> (!grant_o && rsp_o == RSP_WDENY)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |-> (!grant_o && rsp_o == RSP_OK)); // R10
  AST_GRANT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> (rsp_o == RSP_OK)); // R4

endmodule

// File: rtl/seclvl_boot_cfg.sv
module seclvl_boot_cfg
  import seclvl_pkg::*;
#(
  parameter logic [DATA_W-1:0] BSB_DFLT = 8'hFF,
  parameter logic [DATA_W-1:0] SBV_DFLT = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bsb_we_i,
  input  logic              sbv_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              erase_i,
  output logic [DATA_W-1:0] bsb_o,
  output logic [DATA_W-1:0] sbv_o
);

  logic [DATA_W-1:0] bsb_q, bsb_d;
  logic [DATA_W-1:0] sbv_q, sbv_d;
  logic              bsb_en, sbv_en;

  always_comb begin
    bsb_en = erase_i || bsb_we_i;
    sbv_en = erase_i || sbv_we_i;
    bsb_d  = erase_i ? BSB_DFLT : wdata_i;
    sbv_d  = erase_i ? SBV_DFLT : wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsb_q <= BSB_DFLT;
      sbv_q <= SBV_DFLT;
    end else begin
      if (bsb_en) bsb_q <= bsb_d;
      if (sbv_en) sbv_q <= sbv_d;
    end
  end

  assign bsb_o = bsb_q;
  assign sbv_o = sbv_q;

  AST_CFG_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_i |=> (bsb_q == BSB_DFLT && sbv_q == SBV_DFLT)); // R8
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!erase_i && !bsb_we_i && !sbv_we_i) |=> ($stable(bsb_q) && $stable(sbv_q))); // R9

endmodule

// File: rtl/prot_level_ctrl.sv
module prot_level_ctrl
  import seclvl_pkg::*;
#(
  parameter logic [DATA_W-1:0] BSB_DFLT = 8'hFF,
  parameter logic [DATA_W-1:0] SBV_DFLT = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [OP_W-1:0]   req_op,
  input  logic [DATA_W-1:0] req_data,
  output logic              grant,
  output logic [1:0]        resp_code,
  input  logic              lvl_wr,
  input  logic [DATA_W-1:0] lvl_wdata,
  input  logic              chip_erase,
  output logic [DATA_W-1:0] sec_byte,
  output logic [DATA_W-1:0] boot_status,
  output logic [DATA_W-1:0] boot_vector
);

  logic  rst_n_i;
  rank_e rank;
  rsp_e  rsp;
  logic  bsb_we, sbv_we;

  seclvl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  seclvl_level_reg #(.RESET_RANK(RANK_RWP)) u_level (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .wr_en_i   (lvl_wr),
    .wr_data_i (lvl_wdata),
    .erase_i   (chip_erase),
    .rank_o    (rank)
  );

  seclvl_policy u_policy (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .req_valid_i (req_valid),
    .req_op_i    (req_op),
    .rank_i      (rank),
    .grant_o     (grant),
    .rsp_o       (rsp)
  );

  assign bsb_we = grant && (req_op == OP_BSB_WR);
  assign sbv_we = grant && (req_op == OP_SBV_WR);

  seclvl_boot_cfg #(.BSB_DFLT(BSB_DFLT), .SBV_DFLT(SBV_DFLT)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .bsb_we_i (bsb_we),
    .sbv_we_i (sbv_we),
    .wdata_i  (req_data),
    .erase_i  (chip_erase),
    .bsb_o    (boot_status),
    .sbv_o    (boot_vector)
  );

  assign resp_code = rsp;
  assign sec_byte  = rank_to_enc(rank);

  AST_SEC_BYTE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n_i)
    (sec_byte == ENC_OPEN || sec_byte == ENC_WP || sec_byte == ENC_RWP)); // R2

endmodule

// File: tb/prot_level_ctrl_tb_top.sv
module prot_level_ctrl_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [3:0] req_op;
  logic [7:0] req_data;
  logic       grant;
  logic [1:0] resp_code;
  logic       lvl_wr;
  logic [7:0] lvl_wdata;
  logic       chip_erase;
  logic [7:0] sec_byte, boot_status, boot_vector;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  int         m_rank;
  logic [7:0] m_bsb, m_sbv;

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_level_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_data(req_data), .grant(grant), .resp_code(resp_code),
    .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata), .chip_erase(chip_erase),
    .sec_byte(sec_byte), .boot_status(boot_status), .boot_vector(boot_vector)
  );

  function automatic int rank_of(input logic [7:0] b);
    if (b == 8'hFF) return 0;
    if (b == 8'hFE) return 1;
    if (b == 8'hFC) return 2;
    return -1;
  endfunction

  function automatic logic [7:0] byte_of(input int r);
    return (r == 0) ? 8'hFF : (r == 1) ? 8'hFE : 8'hFC;
  endfunction

  function automatic logic [1:0] exp_rsp(input bit v, input int r, input logic [3:0] op);
    if (!v) return 2'b00;
    case (op)
      4'd3, 4'd9, 4'd10:               return 2'b00;
      4'd0, 4'd4, 4'd6:                return (r == 2) ? 2'b10 : 2'b00;
      4'd1, 4'd2, 4'd5, 4'd7, 4'd8:    return (r > 0) ? 2'b01 : 2'b00;
      default:                         return 2'b01;
    endcase
  endfunction

  function automatic string req_tag(input bit v, input int r, input logic [3:0] op);
    if (!v) return "R10";
    if (op > 4'd10) return "R10";
    if (op == 4'd3 || op == 4'd9 || op == 4'd10) return "R7";
    if (r == 0) return "R4";
    if (r == 1) return "R5";
    return "R6";
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    check8(tag, sec_byte, byte_of(m_rank));
    check8(tag, boot_status, m_bsb);
    check8(tag, boot_vector, m_sbv);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input bit v, input logic [3:0] op, input logic [7:0] d,
                      input bit lw, input logic [7:0] lwd, input bit er,
                      input string stag);
    logic [1:0] er_code;
    int         nr;
    req_valid  = v;
    req_op     = op;
    req_data   = d;
    lvl_wr     = lw;
    lvl_wdata  = lwd;
    chip_erase = er;
    #1;
    er_code = exp_rsp(v, m_rank, op);
    check8(req_tag(v, m_rank, op), {6'd0, resp_code}, {6'd0, er_code});
    check8(req_tag(v, m_rank, op), {7'd0, grant}, {7'd0, (v && er_code == 2'b00)});
    if (er) begin
      m_rank = 0; m_bsb = 8'hFF; m_sbv = 8'hF0;
    end else begin
      nr = rank_of(lwd);
      if (lw && nr > m_rank) m_rank = nr;
      if (v && er_code == 2'b00 && op == 4'd7) m_bsb = d;
      if (v && er_code == 2'b00 && op == 4'd8) m_sbv = d;
    end
    @(negedge clk);
    check_state(stag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_valid = 0; req_op = 0; req_data = 0;
    lvl_wr = 0; lvl_wdata = 0; chip_erase = 0;
    m_rank = 2; m_bsb = 8'hFF; m_sbv = 8'hF0;
    repeat (3) @(negedge clk);
    check_state("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_state("R1");

    // R6: reads and writes refused at FCh; R2: lowering rejected
    step(1, 4'd0, 8'h00, 1, 8'hFF, 0, "R2");
    step(1, 4'd7, 8'h12, 1, 8'hFE, 0, "R9");
    // R3: bad encoding rejected
    step(1, 4'd3, 8'h00, 1, 8'h00, 0, "R3");
    // R8: erase opens level
    step(1, 4'd1, 8'h00, 0, 8'h00, 1, "R8");
    // R4 / R9: granted boot writes at FFh
    step(1, 4'd7, 8'h5A, 0, 8'h00, 0, "R9");
    step(1, 4'd8, 8'h3C, 1, 8'hFE, 0, "R2");
    // R5: FEh refuses writes, keeps reads
    step(1, 4'd8, 8'h77, 1, 8'hFF, 0, "R9");
    step(1, 4'd4, 8'h00, 1, 8'hFD, 0, "R3");
    step(1, 4'd12, 8'h00, 1, 8'hFC, 0, "R2");
    // R8: erase beats same-cycle level write and boot write
    step(1, 4'd7, 8'h11, 1, 8'hFC, 1, "R8");
    step(0, 4'd1, 8'h00, 0, 8'h00, 0, "R10");

    for (int i = 0; i < 3000; i++) begin
      bit         v, lw, er;
      logic [3:0] op;
      logic [7:0] d, lwd;
      int unsigned sel;
      v   = ($urandom % 4) != 0;
      op  = 4'($urandom % 16);
      d   = 8'($urandom);
      lw  = ($urandom % 5) == 0;
      sel = $urandom % 4;
      lwd = (sel == 0) ? 8'hFF : (sel == 1) ? 8'hFE : (sel == 2) ? 8'hFC : 8'($urandom);
      er  = ($urandom % 23) == 0;
      step(v, op, d, lw, lwd, er, er ? "R8" : (lw ? "R2" : "R9"));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule